// File: doc/BRIEF.md
# Serial LCD Segment Driver Logic

This block is the digital core of a static LCD segment driver. A serial bit stream enters a 38-stage shift register on the falling edge of the serial clock, but only while the active-low select is low. A level-sensitive hold latch copies the shift register to the segment outputs while the load input is high. Each segment output is its held bit XORed with the backplane. A held 1 therefore drives its segment in antiphase to the backplane, which turns it on. A held 0 drives the segment in phase with the backplane, which leaves it off.

The backplane comes from one of two sources. In external mode it follows the display clock pin. In self-oscillating mode the same pin acts as the oscillator clock, and the backplane is the most significant bit of an 8-bit free-running counter clocked by that pin.

A cascade output carries one chosen shift-register stage, picked by a parameter, to the next device. It is registered on the rising edge of the serial clock, so the next device, which shifts on the falling edge, has half a clock period of hold margin. Cascaded devices share the serial clock, the select and the load. Each device's data input is fed from the previous device's cascade output.

Top module: `lcdseg_driver`

## Requirements
- R1: While `sel_ni` is low, each falling edge of `sclk_i` moves every stage up one position (stage k to stage k+1) and loads `sdata_i` into stage 1. After 38 shifts, the first bit shifted in sits in stage 38, which drives `seg_o[37]`, and the last bit shifted in drives `seg_o[0]`. Stage k drives `seg_o[k-1]`.
- R2: While `sel_ni` is high, falling edges of `sclk_i` leave the shift register unchanged.
- R3: While `load_i` is high, the hold latch takes the shift register contents. While `load_i` is low, the hold latch keeps its value even if the shift register changes.
- R4: If `load_i` stays high during shifting, the segment outputs follow the shift register after every shift.
- R5: Each output `seg_o[i]` equals held bit i XOR `bplane_o`.
- R6: With `selfosc_i` = 0, `bplane_o` equals `dispclk_i`.
- R7: With `selfosc_i` = 1, `bplane_o` is bit 7 of an 8-bit counter. The counter advances on each rising edge of `dispclk_i` and is cleared by a synchronous reset. As a result `bplane_o` is 0 for the first 128 rising edges after reset, 1 for the next 128, and then 0 again.
- R8: `cascade_o` changes only on rising edges of `sclk_i`. On each rising edge it takes the value of stage `TAP`.
- R9: Parameter `TAP` must be 30, 32, 34 or 38, and no greater than `SEG_N`. Any other value stops elaboration.
- R10: In a chain of two devices with `TAP` = 38, a bit reaches stage 1 of the second device exactly 38 shifts after it entered the first device.
- R11: While `rst_ni` is low, the shift register, hold latch and cascade output clear to 0 on the relevant edges, and the divider counter clears to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low synchronous reset |
| sclk_i | input | 1 | Serial clock: shifts on the falling edge, cascade output on the rising edge |
| sdata_i | input | 1 | Serial data in |
| sel_ni | input | 1 | Active-low shift enable |
| load_i | input | 1 | High makes the hold latch transparent |
| dispclk_i | input | 1 | External backplane clock, or oscillator clock in self-oscillating mode |
| selfosc_i | input | 1 | 1 selects the divided backplane, 0 selects the external one |
| bplane_o | output | 1 | Backplane phase |
| seg_o | output | SEG_N | Segment phases |
| cascade_o | output | 1 | Registered tap for the next device |

## Verification
The hardest case to reach from the ports is the chained delay. There, the second device only sees data after a full tap length of shifts, and the data travels through the opposite-edge cascade register. The bench builds a two-device chain, clocks 76 random bits through it and pulses load once. It then compares both devices' segments against the bit history it recorded. The divider's half-period boundary is reached by stepping the oscillator pin exactly 127 and then 128 times after reset.

// File: rtl/lcdseg_pkg.sv
package lcdseg_pkg;
   localparam int unsigned SEG_N_DEF   = 38;
   localparam int unsigned DIV_LOG2_DEF = 8;

   function automatic bit tap_is_legal(input int unsigned tap, input int unsigned n);
      return ((tap == 30) || (tap == 32) || (tap == 34) || (tap == 38)) && (tap <= n);
   endfunction
endpackage

// File: rtl/lcdseg_shreg.sv
module lcdseg_shreg #(
   parameter int unsigned SEG_N = 38,
   parameter int unsigned TAP   = 38
) (
   input  logic             rst_ni,
   input  logic             sclk_i,
   input  logic             sdata_i,
   input  logic             sel_ni,
   output logic [SEG_N-1:0] stage_o,
   output logic             cascade_o
);
   localparam int unsigned TAP_IDX = TAP - 1;

   logic [SEG_N-1:0] stage_q;
   logic             tap_bit;

   // shift on the falling edge, gated by select
   always_ff @(negedge sclk_i) begin
      if (!rst_ni)      stage_q <= '0;
      else if (!sel_ni) stage_q <= {stage_q[SEG_N-2:0], sdata_i};
   end

   assign tap_bit = stage_q[TAP_IDX];

   // cascade register on the opposite edge gives the next device hold margin
   always_ff @(posedge sclk_i) begin
      if (!rst_ni) cascade_o <= 1'b0;
      else         cascade_o <= tap_bit;
   end

   assign stage_o = stage_q;

   // R1: enabled shift moves data up one stage
   a_r1_shift_step: assert property (@(negedge sclk_i) disable iff (!rst_ni)
      !sel_ni |=> (stage_q == {$past(stage_q[SEG_N-2:0]), $past(sdata_i)}));

   // R2: deselected register holds
   a_r2_hold_when_deselected: assert property (@(negedge sclk_i) disable iff (!rst_ni)
      sel_ni |=> (stage_q == $past(stage_q)));

   // R8: cascade output reflects the tap stage seen at the rising edge
   a_r8_cascade_tap: assert property (@(posedge sclk_i) disable iff (!rst_ni)
      1'b1 |=> (cascade_o == $past(stage_q[TAP_IDX])));
endmodule

// File: rtl/lcdseg_hold.sv
module lcdseg_hold #(
   parameter int unsigned SEG_N = 38
) (
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [SEG_N-1:0] d_i,
   output logic [SEG_N-1:0] q_o
);
   always_latch begin
      if (!rst_ni)     q_o <= '0;
      else if (load_i) q_o <= d_i;
   end
endmodule

// File: rtl/lcdseg_bpgen.sv
module lcdseg_bpgen #(
   parameter int unsigned DIV_LOG2 = 8
) (
   input  logic rst_ni,
   input  logic dispclk_i,
   input  logic selfosc_i,
   output logic bplane_o
);
   logic [DIV_LOG2-1:0] div_q;

   always_ff @(posedge dispclk_i) begin
      if (!rst_ni) div_q <= '0;
      else         div_q <= div_q + 1'b1;
   end

   assign bplane_o = selfosc_i ? div_q[DIV_LOG2-1] : dispclk_i;

   // R7: divider advances by one per oscillator edge
   a_r7_div_counts: assert property (@(posedge dispclk_i) disable iff (!rst_ni)
      1'b1 |=> (div_q == DIV_LOG2'($past(div_q) + 1'b1)));
endmodule

// File: rtl/lcdseg_driver.sv
module lcdseg_driver
   import lcdseg_pkg::*;
#(
   parameter int unsigned SEG_N    = SEG_N_DEF,
   parameter int unsigned TAP      = 38,
   parameter int unsigned DIV_LOG2 = DIV_LOG2_DEF
) (
   input  logic             rst_ni,
   input  logic             sclk_i,
   input  logic             sdata_i,
   input  logic             sel_ni,
   input  logic             load_i,
   input  logic             dispclk_i,
   input  logic             selfosc_i,
   output logic             bplane_o,
   output logic [SEG_N-1:0] seg_o,
   output logic             cascade_o
);
   // R9: elaboration-time parameter checks
   generate
      if (!tap_is_legal(TAP, SEG_N)) begin : g_bad_tap
         $error("lcdseg_driver: TAP must be 30, 32, 34 or 38 and <= SEG_N");
      end
      if (DIV_LOG2 < 1) begin : g_bad_div
         $error("lcdseg_driver: DIV_LOG2 must be at least 1");
      end
   endgenerate

   logic [SEG_N-1:0] stage;
   logic [SEG_N-1:0] held;

   lcdseg_shreg #(.SEG_N(SEG_N), .TAP(TAP)) i_shreg (
      .rst_ni   (rst_ni),
      .sclk_i   (sclk_i),
      .sdata_i  (sdata_i),
      .sel_ni   (sel_ni),
      .stage_o  (stage),
      .cascade_o(cascade_o)
   );

   lcdseg_hold #(.SEG_N(SEG_N)) i_hold (
      .rst_ni(rst_ni),
      .load_i(load_i),
      .d_i   (stage),
      .q_o   (held)
   );

   lcdseg_bpgen #(.DIV_LOG2(DIV_LOG2)) i_bpgen (
      .rst_ni   (rst_ni),
      .dispclk_i(dispclk_i),
      .selfosc_i(selfosc_i),
      .bplane_o (bplane_o)
   );

   genvar g;
   generate
      for (g = 0; g < SEG_N; g++) begin : g_seg
         assign seg_o[g] = held[g] ^ bplane_o;
      end
   endgenerate

   // R3: with load low across a clock period the held data does not move
   a_r3_latch_holds: assert property (@(posedge sclk_i) disable iff (!rst_ni)
      (!load_i && $past(!load_i)) |-> $stable(held));
endmodule

// File: tb/test_lcdseg_driver.sv
`timescale 1ns/1ps
module test_lcdseg_driver;
   localparam int N = 38;

   logic          rst_ni = 1'b0;
   logic          sclk = 1'b0;
   logic          sdata = 1'b0;
   logic          sel_n = 1'b1;
   logic          load = 1'b0;
   logic          dispclk = 1'b0;
   logic          selfosc = 1'b0;
   logic          bp_a, bp_b, bp_c;
   logic [N-1:0]  seg_a, seg_b, seg_c;
   logic          casc_a, casc_b, casc_c;

   int total = 0;
   int failed = 0;
   logic [75:0] hist;

   always #2.5 sclk = ~sclk;

   lcdseg_driver i_lcdseg_driver (
      .rst_ni(rst_ni), .sclk_i(sclk), .sdata_i(sdata), .sel_ni(sel_n), .load_i(load),
      .dispclk_i(dispclk), .selfosc_i(selfosc), .bplane_o(bp_a), .seg_o(seg_a), .cascade_o(casc_a));

   lcdseg_driver i_lcdseg_driver_next (
      .rst_ni(rst_ni), .sclk_i(sclk), .sdata_i(casc_a), .sel_ni(sel_n), .load_i(load),
      .dispclk_i(dispclk), .selfosc_i(selfosc), .bplane_o(bp_b), .seg_o(seg_b), .cascade_o(casc_b));

   lcdseg_driver #(.TAP(32)) i_lcdseg_driver_t32 (
      .rst_ni(rst_ni), .sclk_i(sclk), .sdata_i(sdata), .sel_ni(sel_n), .load_i(load),
      .dispclk_i(dispclk), .selfosc_i(selfosc), .bplane_o(bp_c), .seg_o(seg_c), .cascade_o(casc_c));

   function automatic logic [N-1:0] stage_after(input logic [75:0] b, input int shifts);
      logic [N-1:0] r = '0;
      for (int i = 0; i < N; i++)
         if (shifts - 1 - i >= 0) r[i] = b[shifts-1-i];
      return r;
   endfunction

   function automatic logic [N-1:0] seg_expect(input logic [N-1:0] held, input logic bp);
      return held ^ {N{bp}};
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         failed++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic shift_bit(input logic b, input logic sel);
      @(posedge sclk); #1;
      sdata = b; sel_n = sel;
      @(negedge sclk); #1;
   endtask

   task automatic idle();
      @(posedge sclk); #1;
      sel_n = 1'b1;
   endtask

   task automatic pulse_load();
      idle();
      load = 1'b1;
      @(posedge sclk); #1;
      load = 1'b0;
      #1;
   endtask

   task automatic osc_edges(input int n);
      for (int i = 0; i < n; i++) begin
         #1 dispclk = 1'b1;
         #1 dispclk = 1'b0;
      end
      #1;
   endtask

   task automatic do_reset();
      @(posedge sclk); #1;
      rst_ni = 1'b0; sel_n = 1'b1; load = 1'b0;
      osc_edges(3);
      repeat (3) @(posedge sclk);
      #1 rst_ni = 1'b1;
      #1;
   endtask

   task automatic run_all();
      logic [N-1:0] m;
      logic [N-1:0] hold_m;
      void'($urandom(32'd615));

      do_reset();
      check(seg_a == '0, "R11 segments after reset", 64'(seg_a), 64'd0);
      check(casc_a == 1'b0, "R11 cascade after reset", 64'(casc_a), 64'd0);

      // R1 / R3: shift 38 random bits with load low
      for (int k = 0; k < N; k++) begin
         hist[k] = 1'($urandom);
         shift_bit(hist[k], 1'b0);
      end
      m = stage_after(hist, N);
      check(seg_a == '0, "R3 latch holds while load low", 64'(seg_a), 64'd0);
      check(casc_a == 1'b0, "R8 cascade unchanged on falling edge", 64'(casc_a), 64'd0);
      idle();
      check(casc_a == m[N-1], "R8 cascade tap 38 after rising edge", 64'(casc_a), 64'(m[N-1]));
      check(casc_c == m[31], "R8 cascade tap 32 after rising edge", 64'(casc_c), 64'(m[31]));
      pulse_load();
      check(seg_a == seg_expect(m, 1'b0), "R1 R3 segments after load, bp low", 64'(seg_a), 64'(m));
      check(seg_a[N-1] == hist[0], "R1 first bit on seg 37", 64'(seg_a[N-1]), 64'(hist[0]));

      // R5 / R6: external backplane high
      dispclk = 1'b1; #1;
      check(bp_a == 1'b1, "R6 backplane follows external clock", 64'(bp_a), 64'd1);
      check(seg_a == seg_expect(m, 1'b1), "R5 segments with bp high", 64'(seg_a), 64'(~m));
      dispclk = 1'b0; #1;
      check(bp_a == 1'b0, "R6 backplane follows external clock low", 64'(bp_a), 64'd0);

      // R2: deselected shifting has no effect
      for (int k = 0; k < 10; k++) shift_bit(1'($urandom), 1'b1);
      pulse_load();
      check(seg_a == m, "R2 deselected clocks ignored", 64'(seg_a), 64'(m));

      // R4: transparent latch while load held high
      idle();
      load = 1'b1;
      hold_m = m;
      for (int k = 0; k < 6; k++) begin
         logic b;
         b = (k == 0) ? ~hold_m[N-1] : 1'($urandom);
         shift_bit(b, 1'b0);
         hold_m = {hold_m[N-2:0], b};
         check(seg_a == hold_m, "R4 transparent follow", 64'(seg_a), 64'(hold_m));
      end
      idle();
      load = 1'b0;

      // R7: self-oscillating divider
      selfosc = 1'b1;
      do_reset();
      check(bp_a == 1'b0, "R7 bp low after reset", 64'(bp_a), 64'd0);
      osc_edges(127);
      check(bp_a == 1'b0, "R7 bp low after 127 edges", 64'(bp_a), 64'd0);
      osc_edges(1);
      check(bp_a == 1'b1, "R7 bp high after 128 edges", 64'(bp_a), 64'd1);
      check(seg_a == {N{1'b1}}, "R5 cleared latch with bp high", 64'(seg_a), 64'({N{1'b1}}));
      osc_edges(127);
      check(bp_a == 1'b1, "R7 bp high after 255 edges", 64'(bp_a), 64'd1);
      osc_edges(1);
      check(bp_a == 1'b0, "R7 bp low after 256 edges", 64'(bp_a), 64'd0);

      // R10: two-device chain
      selfosc = 1'b0;
      do_reset();
      for (int k = 0; k < 76; k++) begin
         hist[k] = 1'($urandom);
         shift_bit(hist[k], 1'b0);
      end
      pulse_load();
      check(seg_a == stage_after(hist, 76), "R10 first device holds newest bits",
            64'(seg_a), 64'(stage_after(hist, 76)));
      check(seg_b == stage_after(hist, N), "R10 second device delayed one tap length",
            64'(seg_b), 64'(stage_after(hist, N)));
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (150000) @(posedge sclk);
            total++;
            failed++;
            $display("FAIL watchdog expired actual=hung expected=done");
         end
      join_any
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end
endmodule